// File: doc/BRIEF.md
# Multichannel DDR ADC Capture Aligner

The block takes eight converter channels, each delivering a 14-bit sample as two 7-bit halves: one half is captured on the rising edge of its source clock and the other on the falling edge. Channels come in pairs, and each pair has its own source clock, so there are four independent capture clocks. Each channel rebuilds its full sample and pads it to a 16-bit two's-complement word with two zero bits at the bottom. It then writes the word into a small dual-clock buffer. All eight buffers drain into the clock of the first channel pair.

Each pair holds off buffer writes for a fixed count of its own falling edges after reset. The read side starts streaming only when all eight buffers report data, and after that it pops every buffer in every read cycle, so one output beat carries one sample from each channel. An arm pulse clears only the buffers and their read gate. Every channel then restarts writing on its next falling edge, which brings channels whose clocks share a phase back into step. Each channel can also be given one sample of extra delay. The per-channel selection is taken only while no stream is running.

Top module: `adc_capture_aligner`

## Requirements
- R1: While rst_ni is low, vld_o is 0 and every lane of smp_o is 0.
- R2: Each channel's sample is {half captured at rising edge (bits 13:7), half captured at following falling edge (bits 6:0)}. Channel c occupies adc_half_i[7c+6:7c] and smp_o[16c+15:16c], and the output word is {sample, 2'b00}.
- R3: After reset release, no channel writes its buffer on the first 32 falling edges of its pair clock. The first sample written is the one completed on the 33rd falling edge.
- R4: vld_o stays low until all eight buffers are non-empty. From then on vld_o is high in every cycle of adc_clk_i[0], with each channel advancing by exactly one sample per cycle, and no buffer is read while empty.
- R5: When all pair clocks share one phase, the eight lanes of any valid beat hold samples from the same sampling slot.
- R6: While arm_i is high, vld_o is low one read-clock edge after it rises. After arm_i falls, each channel writes from its next falling edge with no new hold count, and the stream restarts aligned.
- R7: A channel whose delay bit is set outputs on its k-th valid beat (k >= 1 after stream start) the sample the undelayed path would give on beat k-1. A channel whose bit is clear outputs the current sample.
- R8: dly_en_i is taken only while no stream is running (after reset, or after arm). Changes made while vld_o is streaming have no effect on smp_o.
- R9: All outputs are registered on rising edges of adc_clk_i[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| adc_clk_i | input | 4 | Source clock per channel pair; bit 0 is also the read clock |
| adc_half_i | input | 56 | DDR half-sample data, 7 bits per channel |
| arm_i | input | 1 | Clears the channel buffers and read gate while high |
| dly_en_i | input | 8 | Per-channel one-sample delay select |
| vld_o | output | 1 | Beat valid for all lanes |
| smp_o | output | 128 | Aligned 16-bit samples, 16 bits per channel |

## Verification
The delicate overlap is a delay reconfiguration that lands while a stream is running, and an arm that clears the buffers in the same window. The bench changes dly_en_i mid-stream and then asserts arm_i with the new selection still applied. It checks that the old selection holds until the stream stops and that the new one takes effect from the first restarted beat. Every lane is compared against a sample value computed from the sampling slot, so a one-slot slip on any channel after the arm is caught.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;
  localparam int unsigned NUM_CH_D     = 8;
  localparam int unsigned CH_PER_CLK_D = 2;
  localparam int unsigned HALF_W_D     = 7;
  localparam int unsigned PAD_W_D      = 2;
  localparam int unsigned FIFO_AW_D    = 3;
  localparam int unsigned WR_HOLD_D    = 32;

  typedef enum logic {RD_IDLE = 1'b0, RD_STREAM = 1'b1} rd_state_e;
endpackage

// File: rtl/adc_pair_capture.sv
module adc_pair_capture #(
  parameter int unsigned CH      = 2,
  parameter int unsigned HALF_W  = 7,
  parameter int unsigned WR_HOLD = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CH*HALF_W-1:0]     half_i,
  output logic [CH*2*HALF_W-1:0]   smp_o,
  output logic                     wr_o
);
  localparam int unsigned CW = $clog2(WR_HOLD + 1);

  logic [CW-1:0] hold_cnt_q;
  logic          wr_en_q;

  // write gate opens after WR_HOLD falling edges
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_q <= '0;
      wr_en_q    <= 1'b0;
    end else if (!wr_en_q) begin
      hold_cnt_q <= hold_cnt_q + 1'b1;
      if (hold_cnt_q == CW'(WR_HOLD - 1)) wr_en_q <= 1'b1;
    end
  end

  assign wr_o = wr_en_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [HALF_W-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hi_q <= '0;
      else         hi_q <= half_i[c*HALF_W +: HALF_W];
    end
    // low half is taken by the buffer on the falling edge
    assign smp_o[c*2*HALF_W +: 2*HALF_W] = {hi_q, half_i[c*HALF_W +: HALF_W]};
  end

  assert_gate_sticky_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> wr_en_q);
endmodule

// File: rtl/adc_cdc_fifo.sv
module adc_cdc_fifo #(
  parameter int unsigned W  = 14,
  parameter int unsigned AW = 3
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin_q, wgray_q, rbin_q, rgray_q;
  logic [AW:0]  wgray_r1_q, wgray_r2_q, rgray_w1_q, rgray_w2_q;
  logic [AW:0]  wbin_n, rbin_n;
  logic         full;

  assign wbin_n = wbin_q + 1'b1;
  assign rbin_n = rbin_q + 1'b1;

  // write side: falling edge of the pair clock
  always_ff @(negedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_i) begin
      wbin_q  <= wbin_n;
      wgray_q <= to_gray(wbin_n);
    end
  end

  always_ff @(negedge wclk_i) begin
    if (wr_i) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(negedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgray_w1_q <= '0;
      rgray_w2_q <= '0;
    end else begin
      rgray_w1_q <= rgray_q;
      rgray_w2_q <= rgray_w1_q;
    end
  end

  assign full = (wgray_q == {~rgray_w2_q[AW:AW-1], rgray_w2_q[AW-2:0]});

  // read side
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_i) begin
      rbin_q  <= rbin_n;
      rgray_q <= to_gray(rbin_n);
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wgray_r1_q <= '0;
      wgray_r2_q <= '0;
    end else begin
      wgray_r1_q <= wgray_q;
      wgray_r2_q <= wgray_r1_q;
    end
  end

  assign empty_o = (rgray_q == wgray_r2_q);
  assign rdata_o = mem[rbin_q[AW-1:0]];

  assert_no_underflow_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
  assert_no_overflow_R4: assert property (@(negedge wclk_i) disable iff (!rst_ni)
    wr_i |-> !full);
endmodule

// File: rtl/adc_ch_delay.sv
module adc_ch_delay #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pop_i,
  input  logic         dly_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (pop_i) begin
      cur_q  <= din_i;
      prev_q <= cur_q;
    end
  end

  assign dout_o = dly_i ? prev_q : cur_q;
endmodule

// File: rtl/adc_capture_aligner.sv
module adc_capture_aligner
  import adc_align_pkg::*;
#(
  parameter int unsigned NUM_CH     = NUM_CH_D,
  parameter int unsigned CH_PER_CLK = CH_PER_CLK_D,
  parameter int unsigned HALF_W     = HALF_W_D,
  parameter int unsigned PAD_W      = PAD_W_D,
  parameter int unsigned FIFO_AW    = FIFO_AW_D,
  parameter int unsigned WR_HOLD    = WR_HOLD_D
) (
  input  logic                                 rst_ni,
  input  logic [NUM_CH/CH_PER_CLK-1:0]         adc_clk_i,
  input  logic [NUM_CH*HALF_W-1:0]             adc_half_i,
  input  logic                                 arm_i,
  input  logic [NUM_CH-1:0]                    dly_en_i,
  output logic                                 vld_o,
  output logic [NUM_CH*(2*HALF_W+PAD_W)-1:0]   smp_o
);
  localparam int unsigned NUM_CLK = NUM_CH / CH_PER_CLK;
  localparam int unsigned SMP_W   = 2 * HALF_W;
  localparam int unsigned OUT_W   = SMP_W + PAD_W;

  logic              rclk;
  logic              buf_rst_n;
  logic [NUM_CH-1:0] empty;
  logic [NUM_CH-1:0] dly_cfg_q;
  logic              all_ready;
  logic              pop;
  logic              vld_q;
  rd_state_e         rd_state_q;

  assign rclk      = adc_clk_i[0];
  assign buf_rst_n = rst_ni & ~arm_i;

  for (genvar p = 0; p < NUM_CLK; p++) begin : g_pair
    logic [CH_PER_CLK*SMP_W-1:0] pair_smp;
    logic                        pair_wr;

    adc_pair_capture #(
      .CH      (CH_PER_CLK),
      .HALF_W  (HALF_W),
      .WR_HOLD (WR_HOLD)
    ) u_cap (
      .clk_i  (adc_clk_i[p]),
      .rst_ni (rst_ni),
      .half_i (adc_half_i[p*CH_PER_CLK*HALF_W +: CH_PER_CLK*HALF_W]),
      .smp_o  (pair_smp),
      .wr_o   (pair_wr)
    );

    for (genvar k = 0; k < CH_PER_CLK; k++) begin : g_lane
      localparam int unsigned CI = p * CH_PER_CLK + k;
      logic [SMP_W-1:0] rd_smp;

      adc_cdc_fifo #(
        .W  (SMP_W),
        .AW (FIFO_AW)
      ) u_fifo (
        .wclk_i  (adc_clk_i[p]),
        .rclk_i  (rclk),
        .rst_ni  (buf_rst_n),
        .wr_i    (pair_wr),
        .wdata_i (pair_smp[k*SMP_W +: SMP_W]),
        .rd_i    (pop),
        .rdata_o (rd_smp),
        .empty_o (empty[CI])
      );

      adc_ch_delay #(
        .W (OUT_W)
      ) u_dly (
        .clk_i  (rclk),
        .rst_ni (rst_ni),
        .pop_i  (pop),
        .dly_i  (dly_cfg_q[CI]),
        .din_i  ({rd_smp, {PAD_W{1'b0}}}),
        .dout_o (smp_o[CI*OUT_W +: OUT_W])
      );
    end
  end

  assign all_ready = ~|empty;

  // read gate belongs to the buffer stage: cleared by arm as well
  always_ff @(posedge rclk or negedge buf_rst_n) begin
    if (!buf_rst_n)     rd_state_q <= RD_IDLE;
    else if (all_ready) rd_state_q <= RD_STREAM;
  end

  assign pop = (rd_state_q == RD_STREAM);

  always_ff @(posedge rclk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= pop;
  end

  always_ff @(posedge rclk or negedge rst_ni) begin
    if (!rst_ni)                    dly_cfg_q <= '0;
    else if (rd_state_q == RD_IDLE) dly_cfg_q <= dly_en_i;
  end

  assign vld_o = vld_q;

  assert_arm_quiet_R6: assert property (@(posedge rclk) disable iff (!rst_ni)
    arm_i |=> !vld_o);
  assert_start_gate_R4: assert property (@(posedge rclk) disable iff (!buf_rst_n)
    $rose(rd_state_q) |-> $past(all_ready));
  assert_cfg_frozen_R8: assert property (@(posedge rclk) disable iff (!rst_ni)
    (pop && $past(pop)) |-> $stable(dly_cfg_q));
  assert_vld_follows_R4: assert property (@(posedge rclk) disable iff (!rst_ni)
    (vld_o && !arm_i) |-> $past(pop));
endmodule

// File: tb/sim_adc_capture_aligner.sv
`timescale 1ns/1ps
module sim_adc_capture_aligner;
  localparam int NCH = 8;

  logic            base_clk = 1'b0;
  logic [3:0]      run      = 4'b0001;
  logic            rst_ni   = 1'b0;
  logic            arm_i    = 1'b0;
  logic [NCH-1:0]  dly_en_i = '0;
  logic [NCH*7-1:0] adc_half_i = '0;
  logic [3:0]      adc_clk_i;
  logic            vld_o;
  logic [NCH*16-1:0] smp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  assign adc_clk_i = {4{base_clk}} & run;

  adc_capture_aligner u0 (
    .rst_ni     (rst_ni),
    .adc_clk_i  (adc_clk_i),
    .adc_half_i (adc_half_i),
    .arm_i      (arm_i),
    .dly_en_i   (dly_en_i),
    .vld_o      (vld_o),
    .smp_o      (smp_o)
  );

  always #2.5 base_clk = ~base_clk;

  function automatic logic [13:0] val(int c, int g);
    return 14'(g * 37 + c * 1801 + 5000);
  endfunction

  function automatic logic [15:0] expw(int c, int g);
    return {val(c, g), 2'b00};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // slot g: high half stable around rising edge at 5g+2.5, low half at falling edge 5g+5
  initial begin
    int g = 0;
    for (int c = 0; c < NCH; c++) adc_half_i[c*7 +: 7] = val(c, 0)[13:7];
    forever begin
      @(posedge base_clk); #1;
      for (int c = 0; c < NCH; c++) adc_half_i[c*7 +: 7] = val(c, g)[6:0];
      @(negedge base_clk); #1;
      g++;
      for (int c = 0; c < NCH; c++) adc_half_i[c*7 +: 7] = val(c, g)[13:7];
    end
  end

  // pair clocks start at different times, all running before reset release
  initial begin
    repeat (2) @(negedge base_clk); run[1] = 1'b1;
    repeat (3) @(negedge base_clk); run[2] = 1'b1;
    repeat (4) @(negedge base_clk); run[3] = 1'b1;
  end

  task automatic wait_vld(string req);
    int n = 0;
    while (vld_o !== 1'b1 && n < 200) begin
      @(negedge base_clk);
      n++;
    end
    chk(req, 16'(vld_o), 16'h1);
  endtask

  // start: slot of beat 0 of this run; off: beats already streamed before this run
  task automatic run_beats(int n, int start, int off, logic [NCH-1:0] mask, string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " R4 valid"}, 16'(vld_o), 16'h1);
      for (int c = 0; c < NCH; c++) begin
        if (mask[c]) begin
          if (i + off > 0) chk({req, " R7"}, smp_o[c*16 +: 16], expw(c, start + i - 1));
        end else begin
          chk({req, " R5"}, smp_o[c*16 +: 16], expw(c, start + i));
        end
      end
      @(negedge base_clk);
    end
  endtask

  initial begin
    int a;
    #50;
    chk("R1 vld", 16'(vld_o), 16'h0);
    for (int c = 0; c < NCH; c++) chk("R1 smp", smp_o[c*16 +: 16], 16'h0);
    #51 rst_ni = 1'b1;                  // release at 101: first written slot 20+32
    @(negedge base_clk);
    chk("R4 low before data", 16'(vld_o), 16'h0);
    wait_vld("R4 start");
    // R2 R3: first beat is slot 52, widened with two zero bits
    run_beats(20, 52, 0, '0, "R2 R3");
    dly_en_i = 8'hA4;                   // R8: ignored while streaming
    run_beats(10, 72, 20, '0, "R8 ignored");

    // R6: arm clears buffers; new selection picked up while idle
    #1 arm_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge base_clk);
      chk("R6 quiet", 16'(vld_o), 16'h0);
    end
    #1 arm_i = 1'b0;
    a = int'(($realtime - 1.0) / 5.0);
    wait_vld("R6 restart");
    run_beats(30, a, 0, 8'hA4, "R6 R8 taken");
    dly_en_i = 8'h00;                   // ignored again
    run_beats(10, a + 30, 30, 8'hA4, "R8 held");

    // second arm removes the delay
    #1 arm_i = 1'b1;
    @(negedge base_clk);
    @(negedge base_clk);
    chk("R6 quiet 2", 16'(vld_o), 16'h0);
    #1 arm_i = 1'b0;
    a = int'(($realtime - 1.0) / 5.0);
    wait_vld("R9 restart 2");
    run_beats(15, a, 0, '0, "R9 R7 off");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule